// File: doc/BRIEF.md
# Write-Trap Destination Freeze Interlock

This block guards the memory data and memory address registers while a memory write is still waiting to learn whether it will trap. The map and garbage-collection lookup decides whether the write traps. While that answer is pending, any instruction that reaches its destination-write cycle with a functional destination is stalled by the `freeze` output. The stall works like a cache-miss stall and holds all pipeline state. When the write is resolved, the held instruction either continues with its destination write intact, or it is cancelled. When it is cancelled, its destination write is inhibited and any early read cycle it launched is aborted. The write that caused the trap is never aborted itself.

The controller has four named states:
- IDLE: no write outstanding.
- PEND: a write has started and is unresolved, and no destination is held yet.
- HOLD: a destination write is frozen.
- CANCEL: a single cycle in which the held destination write is suppressed.

The transitions are:
- IDLE→PEND on a write start.
- PEND→HOLD when a functional destination appears.
- PEND→IDLE on a resolve while no destination is present.
- PEND or HOLD→IDLE on a resolve without trap while a destination is held.
- PEND or HOLD→CANCEL on a resolve with trap while a destination is held.
- CANCEL→IDLE always.

A separate path aborts an early read whenever the instruction that issued it is trapped for any other reason.

Top module: `wtrap_interlock`

## Requirements
- R1: After reset, `freeze`, `dest_inhibit` and `mem_abort` are all 0.
- R2: With no write outstanding (IDLE), `freeze` stays 0 even when `dest_func` is 1.
- R3: In PEND, `freeze` is 1 in the same cycle that `dest_func` is 1.
- R4: Once a destination is held (HOLD), `freeze` stays 1 in every cycle up to and including the cycle in which `wr_resolve` is 1.
- R5: `freeze` is 0 in the cycle after the cycle in which `wr_resolve` is 1.
- R6: If the held write resolves with `wr_trap`=0, `dest_inhibit` is 0 in the release cycle, so the held destination write proceeds.
- R7: If the held write resolves with `wr_trap`=1, `dest_inhibit` is 1 for exactly the following cycle, and `freeze` is 0 in that cycle.
- R8: In the cancel cycle, `mem_abort` is 1 if `early_rd` was 1 when the destination was captured, and 0 otherwise.
- R9: When `insn_trap` and `early_rd` are both 1, `mem_abort` is 1 in that cycle, in any state.
- R10: A write that resolves while no destination is held causes no freeze and no inhibit, even when it traps.
- R11: When `dest_func` and `wr_resolve` arrive in the same PEND cycle, `freeze` is 1 for that one cycle only, and the outcome then applies as in R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | A memory write cycle starts this cycle |
| wr_resolve | input | 1 | Trap outcome of the outstanding write is known this cycle |
| wr_trap | input | 1 | Outcome qualifier: 1 means the write traps |
| dest_func | input | 1 | Current instruction writes a functional destination this cycle |
| early_rd | input | 1 | Current instruction issues an early start-read |
| insn_trap | input | 1 | Current instruction is trapped for a reason outside this block |
| freeze | output | 1 | Pipeline stall request |
| dest_inhibit | output | 1 | Suppress the destination write to the data or address register |
| mem_abort | output | 1 | Cancel the early read cycle before it reaches any bus device |

## Verification
Two functions can fall in the same cycle. One is the capture of a functional destination, which starts a freeze. The other is the resolve strobe of the outstanding write, which ends it. The bench drives `dest_func` and `wr_resolve` together in the PEND cycle. It expects `freeze` for exactly that one cycle, and then the release or cancel outcome on the next cycle. A second coincidence is also exercised: a trap resolve while an early read is held. That case is judged by `dest_inhibit` and `mem_abort` rising together in the cancel cycle.

// File: rtl/wtrap_pkg.sv
package wtrap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PEND   = 2'd1,
        ST_HOLD   = 2'd2,
        ST_CANCEL = 2'd3
    } wtrap_state_t;

endpackage

// File: rtl/wtrap_ctrl.sv
module wtrap_ctrl
    import wtrap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_start,
    input  logic wr_resolve,
    input  logic wr_trap,
    input  logic dest_func,
    output logic freeze,
    output logic dest_inhibit,
    output logic capture,
    output logic cancel
);

    wtrap_state_t state_q, state_d;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_start) state_d = ST_PEND;
            end
            ST_PEND: begin
                if (wr_resolve) begin
                    if (dest_func && wr_trap) state_d = ST_CANCEL;
                    else                      state_d = ST_IDLE;
                end else if (dest_func) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (wr_resolve) state_d = wr_trap ? ST_CANCEL : ST_IDLE;
            end
            ST_CANCEL: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        freeze       = 1'b0;
        dest_inhibit = 1'b0;
        capture      = 1'b0;
        cancel       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PEND: begin
                freeze  = dest_func;
                capture = dest_func;
            end
            ST_HOLD: begin
                freeze = 1'b1;
            end
            ST_CANCEL: begin
                dest_inhibit = 1'b1;
                cancel       = 1'b1;
            end
            default: ;
        endcase
    end

    // R4
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !wr_resolve) |=> freeze);

    // R5
    release_after_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && wr_resolve) |=> !freeze);

    // R6
    no_trap_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && wr_resolve && !wr_trap) |=> !dest_inhibit);

    // R7
    trap_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && wr_resolve && wr_trap) |=> (dest_inhibit && !freeze));

    // R7
    inhibit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dest_inhibit |=> !dest_inhibit);

endmodule

// File: rtl/wtrap_abort.sv
module wtrap_abort (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic cancel,
    input  logic early_rd,
    input  logic insn_trap,
    output logic mem_abort
);

    logic early_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       early_q <= 1'b0;
        else if (capture) early_q <= early_rd;
    end

    always_comb begin
        mem_abort = (cancel && early_q) || (insn_trap && early_rd);
    end

    // R8
    abort_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !early_rd && !cancel) |=> (!mem_abort || (insn_trap && early_rd)));

endmodule

// File: rtl/wtrap_interlock.sv
module wtrap_interlock (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_start,
    input  logic wr_resolve,
    input  logic wr_trap,
    input  logic dest_func,
    input  logic early_rd,
    input  logic insn_trap,
    output logic freeze,
    output logic dest_inhibit,
    output logic mem_abort
);

    logic capture;
    logic cancel;

    wtrap_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_start     (wr_start),
        .wr_resolve   (wr_resolve),
        .wr_trap      (wr_trap),
        .dest_func    (dest_func),
        .freeze       (freeze),
        .dest_inhibit (dest_inhibit),
        .capture      (capture),
        .cancel       (cancel)
    );

    wtrap_abort u_abort (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .cancel    (cancel),
        .early_rd  (early_rd),
        .insn_trap (insn_trap),
        .mem_abort (mem_abort)
    );

    // R7
    inhibit_not_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dest_inhibit |-> !freeze);

endmodule

// File: tb/wtrap_interlock_bench.sv
module wtrap_interlock_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_start = 1'b0, wr_resolve = 1'b0, wr_trap = 1'b0;
    logic dest_func = 1'b0, early_rd = 1'b0, insn_trap = 1'b0;
    logic freeze, dest_inhibit, mem_abort;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wtrap_interlock u_wtrap_interlock (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_resolve(wr_resolve),
        .wr_trap(wr_trap), .dest_func(dest_func), .early_rd(early_rd),
        .insn_trap(insn_trap), .freeze(freeze), .dest_inhibit(dest_inhibit),
        .mem_abort(mem_abort)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic ws, input logic rs, input logic tr,
                       input logic df, input logic er, input logic it);
        @(negedge clk);
        wr_start = ws; wr_resolve = rs; wr_trap = tr;
        dest_func = df; early_rd = er; insn_trap = it;
        #2;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(0,0,0,0,0,0);
        cyc(0,0,0,0,0,0);
        rst_n = 1'b1;
        cyc(0,0,0,0,0,0);
        check("R1 freeze", freeze, 1'b0);
        check("R1 inhibit", dest_inhibit, 1'b0);
        check("R1 abort", mem_abort, 1'b0);
    endtask

    task automatic t_idle_dest();
        cyc(0,0,0,1,0,0);
        check("R2 idle dest", freeze, 1'b0);
        cyc(0,0,0,1,0,0);
        check("R2 idle dest again", freeze, 1'b0);
        cyc(0,0,0,0,0,0);
    endtask

    task automatic t_no_trap();
        cyc(1,0,0,0,0,0);
        check("R2 start cycle", freeze, 1'b0);
        cyc(0,0,0,1,0,0);
        check("R3 pend dest", freeze, 1'b1);
        cyc(0,0,0,1,0,0);
        check("R4 hold", freeze, 1'b1);
        cyc(0,0,0,1,0,0);
        check("R4 hold 2", freeze, 1'b1);
        cyc(0,1,0,1,0,0);
        check("R4 resolve cycle", freeze, 1'b1);
        cyc(0,0,0,1,0,0);
        check("R5 release", freeze, 1'b0);
        check("R6 no inhibit", dest_inhibit, 1'b0);
        check("R6 no abort", mem_abort, 1'b0);
        cyc(0,0,0,0,0,0);
    endtask

    task automatic t_trap(input logic er);
        cyc(1,0,0,0,0,0);
        cyc(0,0,0,1,er,0);
        check("R3 pend dest", freeze, 1'b1);
        check("R8 no abort yet", mem_abort, 1'b0);
        cyc(0,1,1,1,er,0);
        check("R4 resolve cycle", freeze, 1'b1);
        cyc(0,0,0,1,er,0);
        check("R5 release", freeze, 1'b0);
        check("R7 inhibit", dest_inhibit, 1'b1);
        check("R8 abort", mem_abort, er);
        cyc(0,0,0,0,0,0);
        check("R7 single cycle", dest_inhibit, 1'b0);
        check("R8 abort ends", mem_abort, 1'b0);
    endtask

    task automatic t_write_no_dest();
        cyc(1,0,0,0,0,0);
        cyc(0,0,0,0,0,0);
        check("R10 pend no dest", freeze, 1'b0);
        cyc(0,1,1,0,0,0);
        check("R10 resolve", freeze, 1'b0);
        cyc(0,0,0,1,0,0);
        check("R10 no inhibit", dest_inhibit, 1'b0);
        check("R10 idle after", freeze, 1'b0);
        cyc(0,0,0,0,0,0);
    endtask

    task automatic t_same_cycle(input logic tr);
        cyc(1,0,0,0,0,0);
        cyc(0,1,tr,1,1,0);
        check("R11 one freeze", freeze, 1'b1);
        cyc(0,0,0,1,1,0);
        check("R11 freeze ends", freeze, 1'b0);
        check("R11 outcome inhibit", dest_inhibit, tr);
        check("R11 outcome abort", mem_abort, tr);
        cyc(0,0,0,0,0,0);
        check("R11 settled", dest_inhibit, 1'b0);
    endtask

    task automatic t_insn_trap();
        cyc(0,0,0,0,1,1);
        check("R9 idle abort", mem_abort, 1'b1);
        cyc(0,0,0,0,1,0);
        check("R9 no trap", mem_abort, 1'b0);
        cyc(0,0,0,0,0,1);
        check("R9 no early", mem_abort, 1'b0);
        cyc(1,0,0,0,0,0);
        cyc(0,0,0,1,1,1);
        check("R9 pend abort", mem_abort, 1'b1);
        check("R9 still frozen", freeze, 1'b1);
        cyc(0,1,0,1,1,0);
        cyc(0,0,0,0,0,0);
        check("R9 quiet", mem_abort, 1'b0);
    endtask

    initial begin
        t_reset();
        t_idle_dest();
        t_no_trap();
        t_trap(1'b1);
        t_trap(1'b0);
        t_write_no_dest();
        t_same_cycle(1'b0);
        t_same_cycle(1'b1);
        t_insn_trap();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule